// File: doc/BRIEF.md
# Two-Level Address Translation and Access-Rights Unit

This block maps a 32-bit virtual address to a 29-bit physical address. The mapping comes from two tables of page entries. A small fetch table serves only instruction fetches. A larger shared table serves every access. Each entry holds a virtual page tag, an address-space tag, a physical page number, a page-size code and four flags: valid, shared, dirty and a two-bit access-rights field. A lookup is launched with `req_valid`. One cycle later the block returns either a physical address with `rsp_ok` high, or an exception code. The code reports a miss, an access-rights violation, or a first write to a page that is still clean.

An instruction fetch searches the fetch table first and falls back to the shared table. When a fetch is served by the shared table, the block copies that entry into a fetch-table slot. The slot is chosen by a free-running pseudo-random sequence. A write port lets software load any entry of either table. A replacement index counts non-probe lookups and wraps at a programmable boundary, so software can use it to pick a victim in the shared table. A probe lookup reports whether a translation exists without raising any exception.

Top module: `tlbx_top`

## Requirements
- R1: The size code selects the compare mask: 0 gives 1 KB (0xFFFFFC00), 1 gives 4 KB (0xFFFFF000), 2 gives 64 KB (0xFFFF0000), 3 gives 1 MB (0xFFF00000). An entry matches only when it is valid and the virtual address equals the tag (`vpn` placed at bits 31:10) under that mask.
- R2: On success, `rsp_pa` equals the virtual address bits below the mask, ORed with the physical page (`ppn` placed at bits 28:10) under the mask. On any failure `rsp_pa` is zero.
- R3: The address-space tag must equal `req_asid`, except in two cases: the entry is shared, or both `req_sv` and `req_priv` are high.
- R4: An instruction fetch takes the lowest-index matching fetch-table entry. If none matches, it takes the lowest-index matching shared-table entry. A data access consults only the shared table.
- R5: When nothing matches, the code is 1 (miss on read) or 2 (miss on write). A data write gives code 2. An instruction fetch never counts as a write, whatever `req_write` says, so it always gives code 1.
- R6: An instruction fetch that matches in the shared table but not in the fetch table copies the matched entry into a fetch-table slot. A later fetch of that page then still translates after the shared-table entry has been invalidated.
- R7: An instruction fetch passes when `req_priv` is high. In user mode it passes only if rights bit 1 is set; otherwise it gives code 3.
- R8: For privileged data accesses, rights 0 and 2 are read-only, and a write to them gives code 4. Rights 1 and 3 are writable, but a write to such an entry with its dirty flag clear gives code 5.
- R9: For user data accesses, rights 0 and 1 give code 3 on a read and code 4 on a write. Rights 2 is read-only, so a write gives code 4. Rights 3 is writable, with the same dirty-flag rule as R8 (code 5).
- R10: `repl_idx` resets to 0. It advances by one on each non-probe lookup and holds otherwise. It wraps to 0 when the next value would reach the shared-table size, or would equal a nonzero `repl_bound`.
- R11: A probe lookup (`req_probe` high) reports code 0 in every case. A failed probe returns `rsp_ok` low and `rsp_pa` zero. A successful probe returns the same address as a normal lookup.
- R12: After reset all entries are invalid and the response outputs are zero. A lookup issued in one cycle is answered in the next, with `rsp_valid` high for exactly that cycle. For a non-probe lookup, `rsp_ok` is high exactly when the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch a lookup this cycle |
| req_va | input | 32 | Virtual address |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | Data write flag |
| req_priv | input | 1 | Privileged mode |
| req_sv | input | 1 | Single-virtual mode (bypasses the tag check when privileged) |
| req_asid | input | 8 | Current address-space tag |
| req_probe | input | 1 | Probe: no exception, counter untouched |
| ld_en | input | 1 | Write one entry this cycle |
| ld_itlb | input | 1 | 1 = fetch table, 0 = shared table |
| ld_idx | input | $clog2(UTLB_N) | Entry index (low bits used for the fetch table) |
| ld_vpn | input | 22 | Virtual page tag, bits 31:10 |
| ld_asid | input | 8 | Entry address-space tag |
| ld_ppn | input | 19 | Physical page, bits 28:10 |
| ld_valid | input | 1 | Entry valid |
| ld_size | input | 2 | Page-size code |
| ld_shared | input | 1 | Shared flag |
| ld_dirty | input | 1 | Dirty flag |
| ld_prot | input | 2 | Access-rights code |
| repl_bound | input | $clog2(UTLB_N) | Wrap boundary for the counter (0 = table size) |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | 29 | Physical address |
| rsp_exc | output | 3 | Exception code (0 = none) |
| repl_idx | output | $clog2(UTLB_N) | Replacement index |

## Verification
The bench builds the block with a shared table of 8 entries and the default fetch table of 4. Eight entries make the counter's natural wrap reachable within a few lookups, next to a boundary-driven wrap at 3. Every combination of rights, dirty flag, mode, write flag and access kind is swept: 64 cases, each compared with a rights model computed in the bench. All four page sizes are probed on both sides of their mask edge. All sixteen combinations of shared flag, single-virtual mode, privilege and tag equality are exercised as well.

// File: rtl/tlbx_pkg.sv
`timescale 1ns/1ps
package tlbx_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 29;
  localparam int PG_LSB = 10;
  localparam int ASID_W = 8;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int PPN_W  = PA_W - PG_LSB;

  typedef enum logic [2:0] {
    EXC_NONE     = 3'd0,
    EXC_MISS_LD  = 3'd1,
    EXC_MISS_ST  = 3'd2,
    EXC_PROT_LD  = 3'd3,
    EXC_PROT_ST  = 3'd4,
    EXC_FIRST_WR = 3'd5
  } exc_e;

  typedef struct packed {
    logic              valid;
    logic [1:0]        size;
    logic              shared;
    logic              dirty;
    logic [1:0]        prot;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlb_ent_t;

  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] size);
    case (size)
      2'd0:    return 32'hFFFF_FC00;
      2'd1:    return 32'hFFFF_F000;
      2'd2:    return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic logic ent_hit(input tlb_ent_t e, input logic [VA_W-1:0] va,
                                   input logic skip_asid, input logic [ASID_W-1:0] asid);
    logic [VA_W-1:0] m;
    m = page_mask(e.size);
    return e.valid && ((({e.vpn, {PG_LSB{1'b0}}} ^ va) & m) == '0) &&
           (e.shared || skip_asid || (e.asid == asid));
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input tlb_ent_t e, input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    m = page_mask(e.size);
    return (va[PA_W-1:0] & ~m[PA_W-1:0]) | ({e.ppn, {PG_LSB{1'b0}}} & m[PA_W-1:0]);
  endfunction

  function automatic exc_e perm_check(input logic instr, input logic wr, input logic priv,
                                      input logic [1:0] prot, input logic dirty);
    if (instr) return (priv || prot[1]) ? EXC_NONE : EXC_PROT_LD;
    case ({priv, prot})
      3'b100, 3'b110, 3'b010: return wr ? EXC_PROT_ST : EXC_NONE;
      3'b101, 3'b111, 3'b011: return (wr && !dirty) ? EXC_FIRST_WR : EXC_NONE;
      default:                return wr ? EXC_PROT_ST : EXC_PROT_LD;
    endcase
  endfunction
endpackage

// File: rtl/tlbx_match.sv
`timescale 1ns/1ps
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  tlb_ent_t          ents [N],
  input  logic [VA_W-1:0]   va,
  input  logic              skip_asid,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  logic [N-1:0] hv;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hv[g] = ent_hit(ents[g], va, skip_asid, asid);
  end

  // lowest index wins
  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hv[k]) idx = IW'(k);
    end
  end

  assign hit = |hv;
endmodule

// File: rtl/tlbx_lfsr.sv
`timescale 1ns/1ps
module tlbx_lfsr #(
  parameter int         W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= W'(1);
    else        state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/tlbx_repl.sv
`timescale 1ns/1ps
module tlbx_repl #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [IW-1:0] bound,
  output logic [IW-1:0] cnt
);
  logic [IW:0] nxt;
  logic        wrap;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign wrap = (nxt == (IW+1)'(N)) || ((bound != '0) && (nxt == {1'b0, bound}));

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= wrap ? '0 : nxt[IW-1:0];
  end
endmodule

// File: rtl/tlbx_top.sv
`timescale 1ns/1ps
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int ITLB_N = 4,
  parameter int UTLB_N = 64,
  parameter int LFSR_W = 8,
  localparam int IIDX_W = (ITLB_N > 1) ? $clog2(ITLB_N) : 1,
  localparam int UIDX_W = (UTLB_N > 1) ? $clog2(UTLB_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_instr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              req_sv,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_probe,
  input  logic              ld_en,
  input  logic              ld_itlb,
  input  logic [UIDX_W-1:0] ld_idx,
  input  logic [VPN_W-1:0]  ld_vpn,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic [PPN_W-1:0]  ld_ppn,
  input  logic              ld_valid,
  input  logic [1:0]        ld_size,
  input  logic              ld_shared,
  input  logic              ld_dirty,
  input  logic [1:0]        ld_prot,
  input  logic [UIDX_W-1:0] repl_bound,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [2:0]        rsp_exc,
  output logic [UIDX_W-1:0] repl_idx
);
  tlb_ent_t itlb [ITLB_N];
  tlb_ent_t utlb [UTLB_N];
  tlb_ent_t ld_ent, sel_ent;

  logic              skip_asid, i_hit, u_hit, lookup_hit, wr_eff, pass;
  logic              refill_go, ctr_adv;
  logic [IIDX_W-1:0] i_idx, refill_slot;
  logic [UIDX_W-1:0] u_idx;
  logic [LFSR_W-1:0] rnd;
  exc_e              exc_raw;

  assign ld_ent = '{valid: ld_valid, size: ld_size, shared: ld_shared, dirty: ld_dirty,
                    prot: ld_prot, asid: ld_asid, vpn: ld_vpn, ppn: ld_ppn};

  assign skip_asid = req_sv & req_priv;

  tlbx_match #(.N(ITLB_N)) u_imatch (
    .ents(itlb), .va(req_va), .skip_asid(skip_asid), .asid(req_asid),
    .hit(i_hit), .idx(i_idx));

  tlbx_match #(.N(UTLB_N)) u_umatch (
    .ents(utlb), .va(req_va), .skip_asid(skip_asid), .asid(req_asid),
    .hit(u_hit), .idx(u_idx));

  tlbx_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd));

  tlbx_repl #(.N(UTLB_N)) u_repl (
    .clk(clk), .rst_n(rst_n), .adv(ctr_adv), .bound(repl_bound), .cnt(repl_idx));

  assign sel_ent     = (req_instr && i_hit) ? itlb[i_idx] : utlb[u_idx];
  assign lookup_hit  = (req_instr && i_hit) || u_hit;
  assign wr_eff      = req_write && !req_instr;
  assign exc_raw     = lookup_hit ? perm_check(req_instr, wr_eff, req_priv, sel_ent.prot, sel_ent.dirty)
                                  : (wr_eff ? EXC_MISS_ST : EXC_MISS_LD);
  assign pass        = (exc_raw == EXC_NONE);
  assign refill_go   = req_valid && req_instr && !i_hit && u_hit;
  assign refill_slot = rnd[IIDX_W-1:0];
  assign ctr_adv     = req_valid && !req_probe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ITLB_N; k++) itlb[k] <= '0;
      for (int k = 0; k < UTLB_N; k++) utlb[k] <= '0;
    end else begin
      if (ld_en && ld_itlb)      itlb[ld_idx[IIDX_W-1:0]] <= ld_ent;
      else if (refill_go)        itlb[refill_slot]        <= utlb[u_idx];
      if (ld_en && !ld_itlb)     utlb[ld_idx]             <= ld_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_pa    <= '0;
      rsp_exc   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_ok  <= pass;
        rsp_pa  <= pass ? phys_addr(sel_ent, req_va) : '0;
        rsp_exc <= req_probe ? EXC_NONE : exc_raw;
      end
    end
  end
endmodule

// File: rtl/tlbx_chk.sv
`timescale 1ns/1ps
module tlbx_chk #(
  parameter int UTLB_N = 64,
  parameter int UIW    = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_probe,
  input logic           rsp_valid,
  input logic           rsp_ok,
  input logic [28:0]    rsp_pa,
  input logic [2:0]     rsp_exc,
  input logic [UIW-1:0] repl_idx,
  input logic           ctr_adv
);
  p_ctr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(repl_idx) < UTLB_N);

  p_ctr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_probe) |=> ((UIW'(repl_idx - $past(repl_idx)) == UIW'(1)) || (repl_idx == '0)));

  p_ctr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_adv |=> $stable(repl_idx));

  p_probe_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_probe) |=> ((rsp_exc == 3'd0) && (rsp_ok || (rsp_pa == '0))));

  p_ok_matches_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_probe) |=> (rsp_ok == (rsp_exc == 3'd0)));

  p_fail_zero_pa_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_pa == '0));

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind tlbx_top tlbx_chk #(.UTLB_N(UTLB_N), .UIW(UIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_probe(req_probe),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_exc(rsp_exc),
  .repl_idx(repl_idx), .ctr_adv(ctr_adv));

// File: tb/tlbx_top_bench.sv
`timescale 1ns/1ps
module tlbx_top_bench;
  localparam int UN = 8;
  localparam int UW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_instr = 0, req_write = 0, req_priv = 0, req_sv = 0, req_probe = 0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        ld_en = 0, ld_itlb = 0, ld_valid = 0, ld_shared = 0, ld_dirty = 0;
  logic [UW-1:0] ld_idx = '0, repl_bound = '0;
  logic [21:0] ld_vpn = '0;
  logic [7:0]  ld_asid = '0;
  logic [18:0] ld_ppn = '0;
  logic [1:0]  ld_size = '0, ld_prot = '0;
  logic        rsp_valid, rsp_ok;
  logic [28:0] rsp_pa;
  logic [2:0]  rsp_exc;
  logic [UW-1:0] repl_idx;

  int errors = 0, checks = 0, model_cnt = 0;
  logic        got_ok;
  logic [28:0] got_pa;
  logic [2:0]  got_exc;

  always #5 clk = ~clk;

  tlbx_top #(.ITLB_N(4), .UTLB_N(UN)) u_tlbx_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_instr(req_instr),
    .req_write(req_write), .req_priv(req_priv), .req_sv(req_sv), .req_asid(req_asid),
    .req_probe(req_probe), .ld_en(ld_en), .ld_itlb(ld_itlb), .ld_idx(ld_idx), .ld_vpn(ld_vpn),
    .ld_asid(ld_asid), .ld_ppn(ld_ppn), .ld_valid(ld_valid), .ld_size(ld_size),
    .ld_shared(ld_shared), .ld_dirty(ld_dirty), .ld_prot(ld_prot), .repl_bound(repl_bound),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_pa(rsp_pa), .rsp_exc(rsp_exc),
    .repl_idx(repl_idx));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic it, input int idx, input logic [31:0] va, input logic [7:0] as,
                      input logic [18:0] ppn, input logic v, input logic [1:0] sz,
                      input logic sh, input logic d, input logic [1:0] pr);
    ld_en = 1; ld_itlb = it; ld_idx = UW'(idx); ld_vpn = va[31:10]; ld_asid = as;
    ld_ppn = ppn; ld_valid = v; ld_size = sz; ld_shared = sh; ld_dirty = d; ld_prot = pr;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic clear_all();
    for (int k = 0; k < UN; k++) load(1'b0, k, 32'h0, 8'h0, 19'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
    for (int k = 0; k < 4; k++)  load(1'b1, k, 32'h0, 8'h0, 19'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic access(input logic [31:0] va, input logic ins, input logic wr, input logic pv,
                        input logic sv, input logic [7:0] as, input logic pb);
    req_valid = 1; req_va = va; req_instr = ins; req_write = wr; req_priv = pv;
    req_sv = sv; req_asid = as; req_probe = pb;
    @(negedge clk);
    req_valid = 0;
    got_ok = rsp_ok; got_pa = rsp_pa; got_exc = rsp_exc;
    check("R12 rsp_valid", 32'(rsp_valid), 32'd1);
    if (!pb) begin
      if (model_cnt + 1 == UN || (repl_bound != 0 && model_cnt + 1 == int'(repl_bound)))
        model_cnt = 0;
      else
        model_cnt = model_cnt + 1;
    end
    check("R10 repl_idx", 32'(repl_idx), 32'(model_cnt));
  endtask

  function automatic logic [28:0] exp_pa(input logic [31:0] va, input logic [18:0] ppn,
                                         input logic [1:0] sz);
    int sh;
    logic [31:0] pg;
    sh = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
    pg = ({13'd0, ppn} << 10) >> sh << sh;
    return 29'(pg | (va % (32'd1 << sh)));
  endfunction

  function automatic int exp_rights(input logic ins, input logic wr, input logic pv,
                                    input logic [1:0] pr, input logic d);
    logic rd_ok, wr_ok;
    if (ins) return (pv || pr >= 2) ? 0 : 3;
    rd_ok = pv || pr >= 2;
    wr_ok = pv ? (pr % 2 == 1) : (pr == 3);
    if (!rd_ok) return wr ? 4 : 3;
    if (wr && !wr_ok) return 4;
    if (wr && !d) return 5;
    return 0;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] va;
    int e;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 reset rsp_valid", 32'(rsp_valid), 0);
    check("R12 reset rsp_ok", 32'(rsp_ok), 0);
    check("R12 reset rsp_pa", 32'(rsp_pa), 0);
    check("R10 reset repl_idx", 32'(repl_idx), 0);
    rst_n = 1;
    @(negedge clk);
    access(32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0, 1'b0);
    check("R12 empty tables miss", 32'(got_exc), 1);
    @(negedge clk);
    check("R12 rsp_valid single cycle", 32'(rsp_valid), 0);

    // R7 R8 R9: exhaustive rights sweep
    va = 32'h0040_0024;
    for (int c = 0; c < 64; c++) begin
      logic ins, wr, pv, d;
      logic [1:0] pr;
      {ins, wr, pv, d, pr} = 6'(c);
      load(1'b1, 0, 32'h0, 8'h0, 19'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
      load(1'b1, 1, 32'h0, 8'h0, 19'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
      load(1'b1, 2, 32'h0, 8'h0, 19'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
      load(1'b1, 3, 32'h0, 8'h0, 19'h0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
      load(1'b0, 2, va, 8'h11, 19'h00123, 1'b1, 2'd1, 1'b1, d, pr);
      access(va, ins, wr, pv, 1'b0, 8'h22, 1'b0);
      e = exp_rights(ins, wr, pv, pr, d);
      check(ins ? "R7 fetch rights" : (pv ? "R8 priv data rights" : "R9 user data rights"),
            32'(got_exc), 32'(e));
      check("R2 pa on rights outcome", 32'(got_pa), (e == 0) ? 32'(exp_pa(va, 19'h00123, 2'd1)) : 0);
    end

    // R1 R2: page sizes on both sides of the mask edge
    clear_all();
    for (int s = 0; s < 4; s++) begin
      int sh;
      sh = (s == 0) ? 10 : (s == 1) ? 12 : (s == 2) ? 16 : 20;
      load(1'b0, 3, 32'h4AB0_0000, 8'h0, 19'h5A5A5, 1'b1, 2'(s), 1'b0, 1'b1, 2'd0);
      va = 32'h4AB0_0000 + (32'd1 << sh) - 32'd4;
      access(va, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0);
      check("R1 inside page hit", 32'(got_exc), 0);
      check("R2 composed pa", 32'(got_pa), 32'(exp_pa(va, 19'h5A5A5, 2'(s))));
      access(32'h4AB0_0000 + (32'd1 << sh), 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0);
      check("R1 past page edge miss", 32'(got_exc), 1);
    end
    load(1'b0, 3, 32'h4AB0_0000, 8'h0, 19'h5A5A5, 1'b0, 2'd3, 1'b0, 1'b1, 2'd0);
    access(32'h4AB0_0010, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0);
    check("R1 invalid entry misses", 32'(got_exc), 1);

    // R3: address-space tag rule, all 16 combinations
    clear_all();
    for (int c = 0; c < 16; c++) begin
      logic sh, sv, pv, m;
      {sh, sv, pv, m} = 4'(c);
      load(1'b0, 4, 32'h1000_0000, 8'h3C, 19'h00777, 1'b1, 2'd3, sh, 1'b1, 2'd3);
      access(32'h1000_0100, 1'b0, 1'b0, pv, sv, m ? 8'h3C : 8'h3D, 1'b0);
      check("R3 tag rule", 32'(got_exc), (sh || (sv && pv) || m) ? 0 : 1);
    end

    // R4 R5: table order
    clear_all();
    load(1'b0, 0, 32'h2000_0000, 8'h0, 19'h0AAAA, 1'b1, 2'd1, 1'b1, 1'b1, 2'd3);
    load(1'b1, 3, 32'h2000_0000, 8'h0, 19'h0CCCC, 1'b1, 2'd1, 1'b1, 1'b1, 2'd3);
    load(1'b1, 1, 32'h2000_0000, 8'h0, 19'h0BBBB, 1'b1, 2'd1, 1'b1, 1'b1, 2'd3);
    access(32'h2000_0044, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R4 fetch takes lowest fetch entry", 32'(got_pa), 32'(exp_pa(32'h2000_0044, 19'h0BBBB, 2'd1)));
    access(32'h2000_0044, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R4 data uses shared table", 32'(got_pa), 32'(exp_pa(32'h2000_0044, 19'h0AAAA, 2'd1)));
    load(1'b0, 0, 32'h2000_0000, 8'h0, 19'h0AAAA, 1'b0, 2'd1, 1'b1, 1'b1, 2'd3);
    access(32'h2000_0044, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R4 data ignores fetch table", 32'(got_exc), 1);
    access(32'h2000_0044, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R5 data write miss", 32'(got_exc), 2);
    access(32'h3000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R5 fetch miss ignores write", 32'(got_exc), 1);

    // R6: refill into fetch table
    clear_all();
    load(1'b0, 5, 32'h0080_0000, 8'h0, 19'h01230, 1'b1, 2'd2, 1'b1, 1'b0, 2'd2);
    access(32'h0080_1234, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R6 fetch via shared table", 32'(got_pa), 32'(exp_pa(32'h0080_1234, 19'h01230, 2'd2)));
    load(1'b0, 5, 32'h0080_0000, 8'h0, 19'h01230, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2);
    access(32'h0080_1234, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R6 fetch served by copied entry", 32'(got_pa), 32'(exp_pa(32'h0080_1234, 19'h01230, 2'd2)));
    access(32'h0080_1234, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R6 data sees invalidated entry", 32'(got_exc), 1);

    // R11: probe
    clear_all();
    load(1'b0, 1, 32'h0500_0000, 8'h0, 19'h00042, 1'b1, 2'd0, 1'b1, 1'b1, 2'd0);
    access(32'h0500_0008, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b1);
    check("R11 probe rights fail code", 32'(got_exc), 0);
    check("R11 probe rights fail ok", 32'(got_ok), 0);
    check("R11 probe rights fail pa", 32'(got_pa), 0);
    access(32'h0600_0008, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0, 1'b1);
    check("R11 probe miss code", 32'(got_exc), 0);
    check("R11 probe miss pa", 32'(got_pa), 0);
    access(32'h0500_0008, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b1);
    check("R11 probe hit pa", 32'(got_pa), 32'(exp_pa(32'h0500_0008, 19'h00042, 2'd0)));
    check("R11 probe hit ok", 32'(got_ok), 1);
    access(32'h0500_0008, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0);
    check("R9 non-probe user rights 0", 32'(got_exc), 3);

    // R10: wrap at boundary, then at table size
    repl_bound = UW'(3);
    for (int k = 0; k < 7; k++) access(32'h7000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0);
    repl_bound = '0;
    for (int k = 0; k < 10; k++) access(32'h7000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule